// File: doc/BRIEF.md
# Serial Link Watchdog and Baud Configuration

This block sits beside a UART shifter. It keeps the settings for that shifter, produces the 16x oversampling tick, and watches the receive side for silence. Firmware programs four 16-bit registers through a plain write port. These are a feature word, a baud divisor and two timeout values. The baud divisor `N` sets a line rate of 4 MHz / (16 * (N + 1)). The block turns a 4 MHz reference enable into one `baud_tick` pulse for every `N + 1` reference pulses, which is sixteen ticks per bit time.

Two watchdogs share a 10 ms time base, which a prescaler derives from the system clock. Each watchdog counts time-base periods since it was last restarted. A restart comes from a `char_valid` strobe (a correctly received character) or from a write to that watchdog's own timeout register. The receive watchdog raises `rx_zero` when its count reaches its limit. The controller uses `rx_zero` to force its input data to zero. The transmit watchdog raises `tx_hold` in the same way, and the shifter uses it to stop sending. Each flag can be turned off with its own feature bit.

There is no data stream at the edge of this block. Every input is sampled on each clock and always accepted, so nothing applies back-pressure. Writes take effect on the clock edge at which `wr_en` is high.

Top module: `link_guard`

## Requirements
- R1: After reset, the feature word is 0x0007, the baud divisor is 3 and both timeouts are 20. Both flags are low right after reset. Both flags are high once 20 time-base periods have passed with no strobe.
- R2: `baud_tick` is a one-cycle pulse after every `N + 1` `ref_en` pulses, where `N` is bits 7:0 of the baud register (`wr_sel` = 1). The pulse period in clocks is therefore (N+1) times the `ref_en` period.
- R3: Bits 15:8 of a baud register write have no effect on the `baud_tick` period.
- R4: When feature bit 0 is set (`wr_sel` = 0), `rx_zero` stays low for at least T-1 time-base periods after the last restart and is high no later than T periods after it. T is the receive timeout (`wr_sel` = 2).
- R5: When feature bit 1 is set, `tx_hold` follows the same rule using the transmit timeout (`wr_sel` = 3).
- R6: A `char_valid` strobe restarts both watchdogs. In the cycle after the strobe, a flag whose timeout is non-zero is low.
- R7: A flag whose feature bit is clear stays low. Its counter keeps running, so setting the bit again after the timeout has elapsed raises the flag at once.
- R8: A timeout of 0 makes the flag high whenever its watchdog is enabled, including right after a strobe.
- R9: A write to one timeout register restarts only that watchdog. The other flag keeps its state.
- R10: Feature bits 15:2 have no effect on either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_en | input | 1 | One-cycle pulse at the 4 MHz reference rate |
| char_valid | input | 1 | Strobe for a correctly received character |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 2 | Register select: 0 feature, 1 baud, 2 receive timeout, 3 transmit timeout |
| wr_data | input | 16 | Write data |
| baud_tick | output | 1 | 16x oversampling tick |
| rx_zero | output | 1 | Receive watchdog expired: clear controller inputs |
| tx_hold | output | 1 | Transmit watchdog expired: inhibit sending |

## Verification
The bench builds `link_guard` with `TIME_DIV` = 8, so one timeout unit is eight clocks instead of two million. With that setting the reset timeouts of 20 units run out in 160 cycles, and random timeouts of a few units can be checked against their lower and upper bounds many times in one run. The reference enable is driven every four clocks, so divisors up to 15 give tick periods short enough to measure repeatedly. Baud high bytes and feature bits 15:2 are randomised to show that they have no effect.

// File: rtl/lg_pkg.sv
package lg_pkg;
  localparam int REG_W = 16;
  localparam int DIV_W = 8;

  typedef enum logic [1:0] {
    SEL_FEAT = 2'd0,
    SEL_BAUD = 2'd1,
    SEL_RXTO = 2'd2,
    SEL_TXTO = 2'd3
  } reg_sel_e;

  localparam logic [3:0]       FEAT_RST = 4'h7;
  localparam logic [DIV_W-1:0] BAUD_RST = 8'd3;
  localparam logic [REG_W-1:0] TO_RST   = 16'd20;
endpackage

// File: rtl/lg_baud_div.sv
module lg_baud_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (ref_en) begin
      if (cnt_q >= div_n) begin
        cnt_q <= '0;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // R2
  tick_follows_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(ref_en));
endmodule

// File: rtl/lg_timebase.sv
module lg_timebase #(
  parameter int TIME_DIV = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic step
);
  localparam int CW = (TIME_DIV > 2) ? $clog2(TIME_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIME_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      step  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      step  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      step  <= 1'b0;
    end
  end

  // R4
  step_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> !step);
endmodule

// File: rtl/lg_watchdog.sv
module lg_watchdog #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             restart,
  input  logic             cfg_wr,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] elapsed_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      elapsed_q <= '0;
    else if (step && (elapsed_q != '1))
      elapsed_q <= elapsed_q + 1'b1;
  end

  assign expired = enable && (elapsed_q >= limit);

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !restart && !cfg_wr) |=> expired);

  // R4
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> ($past(step) || $past(cfg_wr) || $past(restart)));
endmodule

// File: rtl/link_guard.sv
module link_guard
  import lg_pkg::*;
#(
  parameter int TIME_DIV = 2_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             char_valid,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             baud_tick,
  output logic             rx_zero,
  output logic             tx_hold
);
  localparam int N_WD = 2;

  logic [3:0]       feat_q;
  logic [DIV_W-1:0] baud_q;
  logic             feat_wr, baud_wr, step;
  logic [N_WD-1:0]  flags;

  assign feat_wr = wr_en && (wr_sel == SEL_FEAT);
  assign baud_wr = wr_en && (wr_sel == SEL_BAUD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      feat_q <= FEAT_RST;
      baud_q <= BAUD_RST;
    end else begin
      if (feat_wr) feat_q <= wr_data[3:0];
      if (baud_wr) baud_q <= wr_data[DIV_W-1:0];
    end
  end

  lg_baud_div #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .restart(baud_wr),
    .div_n(baud_q), .tick(baud_tick)
  );

  lg_timebase #(.TIME_DIV(TIME_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .step(step)
  );

  for (genvar g = 0; g < N_WD; g++) begin : g_wd
    logic [REG_W-1:0] lim_q;
    logic             lim_wr;

    assign lim_wr = wr_en && (wr_sel == 2'(g + 2));

    always_ff @(posedge clk) begin
      if (!rst_n)      lim_q <= TO_RST;
      else if (lim_wr) lim_q <= wr_data;
    end

    lg_watchdog #(.CNT_W(REG_W)) u_wd (
      .clk(clk), .rst_n(rst_n), .step(step),
      .restart(char_valid || lim_wr), .cfg_wr(feat_wr),
      .enable(feat_q[g]), .limit(lim_q), .expired(flags[g])
    );
  end

  assign rx_zero = flags[0];
  assign tx_hold = flags[1];

  // R6
  strobe_clears_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !wr_en && (g_wd[0].lim_q != '0)) |=> !rx_zero);

  // R7
  rx_disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_q[0] |-> !rx_zero);
endmodule

// File: tb/tb_link_guard.sv
module tb_link_guard;
  localparam int TDIV = 8;
  localparam int REFP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_en = 1'b0;
  logic        char_valid = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        baud_tick, rx_zero, tx_hold;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  link_guard #(.TIME_DIV(TDIV)) dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .char_valid(char_valid),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .baud_tick(baud_tick), .rx_zero(rx_zero), .tx_hold(tx_hold)
  );

  function automatic int tick_period(input int n);
    return (n + 1) * REFP;
  endfunction

  function automatic int quiet_cycles(input int t);
    return (t > 0) ? TDIV * (t - 1) : 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk);
    char_valid = 1'b1;
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic measure(output int per);
    while (!baud_tick) @(negedge clk);
    @(negedge clk);
    while (!baud_tick) @(negedge clk);
    @(negedge clk);
    per = 1;
    while (!baud_tick) begin
      @(negedge clk);
      per++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int flag_of(input int idx);
    return (idx == 0) ? int'(rx_zero) : int'(tx_hold);
  endfunction

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ref_en = (ph == 0);
      ph = (ph + 1) % REFP;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung (R1..)  actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int per, per2, t, idx, n;
    logic [15:0] f;
    void'($urandom(32'd1234));
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_zero after reset", rx_zero, 0);
    check("R1 tx_hold after reset", tx_hold, 0);
    measure(per);
    check("R1 R2 reset tick period", per, tick_period(3));
    idle(20 * TDIV + 2);
    check("R1 rx_zero after 20 units", rx_zero, 1);
    check("R1 tx_hold after 20 units", tx_hold, 1);

    // R6 strobe clears both
    strobe();
    check("R6 rx_zero after strobe", rx_zero, 0);
    check("R6 tx_hold after strobe", tx_hold, 0);

    // R3 high byte ignored
    wr(2'd1, 16'h0005);
    measure(per);
    wr(2'd1, 16'hAB05);
    measure(per2);
    check("R3 high byte no effect", per2, per);
    check("R3 R2 period N=5", per2, tick_period(5));

    // R2 random divisors
    for (int i = 0; i < 8; i++) begin
      n = int'($urandom_range(0, 15));
      wr(2'd1, {8'($urandom), 8'(n)});
      measure(per);
      check("R2 random divisor period", per, tick_period(n));
    end

    // R7 disable then re-enable
    wr(2'd2, 16'd2);
    wr(2'd3, 16'd2);
    wr(2'd0, 16'h0000);
    idle(4 * TDIV);
    check("R7 rx_zero disabled", rx_zero, 0);
    check("R7 tx_hold disabled", tx_hold, 0);
    wr(2'd0, 16'h0003);
    check("R7 rx_zero re-enabled", rx_zero, 1);
    check("R7 tx_hold re-enabled", tx_hold, 1);

    // R9 write one timeout restarts only that watchdog
    wr(2'd2, 16'd20);
    check("R9 rx_zero restarted", rx_zero, 0);
    check("R9 tx_hold kept", tx_hold, 1);

    // R8 zero timeout
    wr(2'd2, 16'd0);
    check("R8 rx_zero with zero limit", rx_zero, 1);
    strobe();
    check("R8 rx_zero after strobe zero limit", rx_zero, 1);
    check("R6 tx_hold after strobe", tx_hold, 0);

    // R10 upper feature bits ignored
    wr(2'd0, 16'hFFFC);
    check("R10 rx_zero with only high bits", rx_zero, 0);
    idle(4 * TDIV);
    check("R10 tx_hold with only high bits", tx_hold, 0);
    wr(2'd0, 16'hFFF1);
    check("R10 rx_zero bit0 with high bits", rx_zero, 1);

    // R4 R5 random timeouts
    for (int i = 0; i < 16; i++) begin
      idx = int'($urandom_range(0, 1));
      t = int'($urandom_range(1, 6));
      f = {12'($urandom), 2'($urandom), 2'b00};
      f[idx] = 1'b1;
      wr(2'd0, f);
      wr(2'(idx + 2), 16'(t));
      idle(quiet_cycles(t));
      check(idx == 0 ? "R4 rx_zero low before limit" : "R5 tx_hold low before limit",
            flag_of(idx), 0);
      idle(TDIV);
      check(idx == 0 ? "R4 rx_zero high at limit" : "R5 tx_hold high at limit",
            flag_of(idx), 1);
      strobe();
      check("R6 flag low after strobe", flag_of(idx), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule